// File: doc/BRIEF.md
# Serial Control-Line Port Registers

This block holds the register-side state for the general-purpose control lines of a two-channel serial port. A small output register drives the request-to-send and spare output lines; software changes it through three independent write strobes: one that sets every bit written as one, one that clears every bit written as one, and one that overwrites only the request-to-send bits directly. The register contents feed the downstream flow-control logic.

On the input side, every channel brings in four lines: clear-to-send, carrier, ring and a spare test input. All of them pass through a two-flop synchronizer and can be read back as levels at any time. The clear-to-send and carrier lines of each channel also have transition detectors. A detected transition sets a sticky flag in the upper half of a change word. The lower half of that word shows the present synchronized levels of the same lines. A read strobe on the change word clears the flags at the next clock edge. A transition that lands in the same cycle as the read is kept, not lost. Bus address decoding is done outside the block and arrives here as strobes.

Top module: `modem_port_regs`

## Requirements
- R1: When `set_we` is high, every bit of `op_q` whose `set_data` bit is one reads one after the next rising clock edge.
- R2: When `clr_we` is high, every bit of `op_q` whose `clr_data` bit is one reads zero after the next rising clock edge, unless R3 applies.
- R3: Priority within one cycle, highest first: set, then clear, then direct write. A bit that is both set and cleared in the same cycle ends at one.
- R4: When `dir_we` is high, `op_q[NCH-1:0]` takes `dir_data` at the next edge, unless R3 overrides it. The bits `op_q[OUT_W-1:NCH]` are not changed by a direct write.
- R5: `op_q` keeps its value in any cycle with no write strobe.
- R6: `inport_q` holds the synchronized pin levels, packed as {tin, rin, cin, cts}, each field NCH bits wide, with channel 0 in the lowest bit of each field. A pin level sampled at one rising edge appears after the second rising edge.
- R7: `chg_word[4*NCH-1:2*NCH]` holds sticky change flags in the order {cin, cts}, each field NCH bits wide. A flag is set one edge after its synchronized level changes, and it stays set until it is read.
- R8: A cycle with `chg_rd` high clears all change flags at that edge, except the flags covered by R9.
- R9: A transition whose flag would be set at the same edge as a read still sets that flag.
- R10: `chg_word[2*NCH-1:0]` shows the synchronized cin and cts levels in the order {cin, cts}, with the same timing as `inport_q`.
- R11: `rst_n` low clears all state at once. After `rst_n` rises, the block ignores writes until two rising edges have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_we | input | 1 | Set-bits write strobe |
| set_data | input | OUT_W | Bits to set |
| clr_we | input | 1 | Clear-bits write strobe |
| clr_data | input | OUT_W | Bits to clear |
| dir_we | input | 1 | Direct write strobe for the request-to-send bits |
| dir_data | input | NCH | New request-to-send bits |
| chg_rd | input | 1 | Change word read strobe |
| cts_pin | input | NCH | Clear-to-send pins, one per channel |
| cin_pin | input | NCH | Carrier pins |
| rin_pin | input | NCH | Ring pins |
| tin_pin | input | NCH | Spare test input pins |
| op_q | output | OUT_W | Output port register |
| inport_q | output | 4*NCH | Synchronized input levels |
| chg_word | output | 4*NCH | Change flags (upper half) and levels (lower half) |

## Verification
The bench uses the default parameters: two channels, a four-bit output register and two synchronizer stages. With these values, the direct write reaches only the two low bits, so the bench can watch the two upper bits to confirm that a direct write leaves them alone. Both channels' detectors share one read strobe, so the bench can show that a read clears one channel's flag while the other channel's transition in the same cycle survives. The two-edge latency is short enough that random pin toggles often line up with a read.

// File: rtl/mp_pkg.sv
package mp_pkg;
  // Input line kinds per channel, lowest field first in the packed input word.
  localparam int KIND_CTS = 0;
  localparam int KIND_CIN = 1;
  localparam int KIND_RIN = 2;
  localparam int KIND_TIN = 3;
  localparam int NUM_KINDS = 4;
  // Lines that carry a transition detector (cts and cin fields).
  localparam int NUM_WATCHED_KINDS = 2;
endpackage

// File: rtl/mp_rst_sync.sv
module mp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/mp_sync.sv
module mp_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] stage_q;
  logic [STAGES-1:0][W-1:0] stage_d;

  always_comb begin
    stage_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/mp_out_reg.sv
module mp_out_reg #(
  parameter int OUT_W = 4,
  parameter int DIR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic [OUT_W-1:0] set_data,
  input  logic             clr_we,
  input  logic [OUT_W-1:0] clr_data,
  input  logic             dir_we,
  input  logic [DIR_W-1:0] dir_data,
  output logic [OUT_W-1:0] op_o
);
  logic [OUT_W-1:0] op_q;
  logic [OUT_W-1:0] op_d;
  logic             op_en;

  // Lowest priority first, so later steps override earlier ones.
  always_comb begin
    op_d = op_q;
    if (dir_we) op_d[DIR_W-1:0] = dir_data;
    if (clr_we) op_d = op_d & ~clr_data;
    if (set_we) op_d = op_d | set_data;
    op_en = set_we | clr_we | dir_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     op_q <= '0;
    else if (op_en) op_q <= op_d;
  end

  assign op_o = op_q;
endmodule

// File: rtl/mp_chg_latch.sv
module mp_chg_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic         rd_i,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] chg_q;
  logic [W-1:0] chg_d;
  logic [W-1:0] edge_s;

  always_comb begin
    edge_s = lvl_i ^ prev_q;
    // A fresh edge is ORed in after the read clear, so it survives the read.
    chg_d  = (rd_i ? '0 : chg_q) | edge_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      chg_q  <= '0;
    end else begin
      prev_q <= lvl_i;
      chg_q  <= chg_d;
    end
  end

  assign chg_o = chg_q;
endmodule

// File: rtl/modem_port_regs.sv
module modem_port_regs #(
  parameter int NCH         = 2,
  parameter int OUT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_we,
  input  logic [OUT_W-1:0]     set_data,
  input  logic                 clr_we,
  input  logic [OUT_W-1:0]     clr_data,
  input  logic                 dir_we,
  input  logic [NCH-1:0]       dir_data,
  input  logic                 chg_rd,
  input  logic [NCH-1:0]       cts_pin,
  input  logic [NCH-1:0]       cin_pin,
  input  logic [NCH-1:0]       rin_pin,
  input  logic [NCH-1:0]       tin_pin,
  output logic [OUT_W-1:0]     op_q,
  output logic [4*NCH-1:0]     inport_q,
  output logic [4*NCH-1:0]     chg_word
);
  import mp_pkg::*;

  localparam int IN_W    = NUM_KINDS * NCH;
  localparam int WATCH_W = NUM_WATCHED_KINDS * NCH;

  logic               rst_core_n;
  logic [IN_W-1:0]    pins_raw;
  logic [IN_W-1:0]    pins_sync;
  logic [WATCH_W-1:0] watch_lvl;
  logic [WATCH_W-1:0] watch_chg;

  mp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_core_n)
  );

  // Pack the pins into the input word, one field per line kind.
  for (genvar c = 0; c < NCH; c++) begin : g_pack
    assign pins_raw[KIND_CTS*NCH + c] = cts_pin[c];
    assign pins_raw[KIND_CIN*NCH + c] = cin_pin[c];
    assign pins_raw[KIND_RIN*NCH + c] = rin_pin[c];
    assign pins_raw[KIND_TIN*NCH + c] = tin_pin[c];
  end

  mp_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .async_i(pins_raw), .sync_o(pins_sync)
  );

  assign watch_lvl = pins_sync[WATCH_W-1:0];

  mp_chg_latch #(.W(WATCH_W)) u_chg (
    .clk(clk), .rst_n(rst_core_n), .lvl_i(watch_lvl), .rd_i(chg_rd),
    .chg_o(watch_chg)
  );

  mp_out_reg #(.OUT_W(OUT_W), .DIR_W(NCH)) u_out (
    .clk(clk), .rst_n(rst_core_n),
    .set_we(set_we), .set_data(set_data),
    .clr_we(clr_we), .clr_data(clr_data),
    .dir_we(dir_we), .dir_data(dir_data),
    .op_o(op_q)
  );

  assign inport_q = pins_sync;
  assign chg_word = {watch_chg, watch_lvl};
endmodule

// File: rtl/modem_port_regs_chk.sv
module modem_port_regs_chk #(
  parameter int NCH   = 2,
  parameter int OUT_W = 4
) (
  input logic             clk,
  input logic             rst_core_n,
  input logic             set_we,
  input logic [OUT_W-1:0] set_data,
  input logic             clr_we,
  input logic [OUT_W-1:0] clr_data,
  input logic             dir_we,
  input logic [NCH-1:0]   dir_data,
  input logic             chg_rd,
  input logic [OUT_W-1:0] op_q,
  input logic [4*NCH-1:0] chg_word
);
  localparam int WW = 2 * NCH;
  logic [WW-1:0] lvl;
  logic [WW-1:0] flg;
  logic [WW-1:0] lvl_prev;

  assign lvl = chg_word[WW-1:0];
  assign flg = chg_word[2*WW-1:WW];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) lvl_prev <= '0;
    else             lvl_prev <= lvl;
  end

  // R1
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    set_we |=> ((op_q & $past(set_data)) == $past(set_data)));
  // R2
  clr_lands_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (clr_we && !set_we) |=> ((op_q & $past(clr_data)) == '0));
  // R3
  set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (set_we && clr_we) |=> ((op_q & $past(set_data & clr_data)) == $past(set_data & clr_data)));
  // R4
  dir_low_only_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (dir_we && !set_we && !clr_we) |=>
      (op_q[NCH-1:0] == $past(dir_data)) && (op_q[OUT_W-1:NCH] == $past(op_q[OUT_W-1:NCH])));
  // R5
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(set_we || clr_we || dir_we) |=> $stable(op_q));
  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !chg_rd |=> ((flg & $past(flg)) == $past(flg)));
  // R7
  edge_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (lvl != lvl_prev) |=> ((flg & $past(lvl ^ lvl_prev)) == $past(lvl ^ lvl_prev)));
  // R8
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (chg_rd && (lvl == lvl_prev)) |=> (flg == '0));
  // R9
  read_keeps_new_edge_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (chg_rd && (lvl != lvl_prev)) |=> (flg == $past(lvl ^ lvl_prev)));
endmodule

bind modem_port_regs modem_port_regs_chk #(.NCH(NCH), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_core_n(rst_core_n),
  .set_we(set_we), .set_data(set_data),
  .clr_we(clr_we), .clr_data(clr_data),
  .dir_we(dir_we), .dir_data(dir_data),
  .chg_rd(chg_rd), .op_q(op_q), .chg_word(chg_word)
);

// File: tb/modem_port_regs_tb.sv
module modem_port_regs_tb;
  localparam int NCH   = 2;
  localparam int OUT_W = 4;
  localparam int IW    = 4 * NCH;
  localparam int WW    = 2 * NCH;
  localparam time CLK_HALF = 10ns;

  logic clk = 1'b0;
  logic rst_n;
  logic set_we, clr_we, dir_we, chg_rd;
  logic [OUT_W-1:0] set_data, clr_data;
  logic [NCH-1:0] dir_data, cts_pin, cin_pin, rin_pin, tin_pin;
  logic [OUT_W-1:0] op_q;
  logic [IW-1:0] inport_q, chg_word;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // expected state
  logic [OUT_W-1:0] op_m;
  logic [IW-1:0] s1_m, s2_m;
  logic [WW-1:0] prev_m, flg_m;

  always #(CLK_HALF) clk = ~clk;

  modem_port_regs #(.NCH(NCH), .OUT_W(OUT_W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .set_we(set_we), .set_data(set_data), .clr_we(clr_we), .clr_data(clr_data),
    .dir_we(dir_we), .dir_data(dir_data), .chg_rd(chg_rd),
    .cts_pin(cts_pin), .cin_pin(cin_pin), .rin_pin(rin_pin), .tin_pin(tin_pin),
    .op_q(op_q), .inport_q(inport_q), .chg_word(chg_word)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected output register after one edge: set over clear over direct write.
  function automatic logic [OUT_W-1:0] op_next(
      input logic [OUT_W-1:0] cur, input logic sw, input logic [OUT_W-1:0] sd,
      input logic cw, input logic [OUT_W-1:0] cd, input logic dw, input logic [NCH-1:0] dd);
    logic [OUT_W-1:0] r;
    r = cur;
    if (dw) r[NCH-1:0] = dd;
    if (cw) r = r & ~cd;
    if (sw) r = r | sd;
    return r;
  endfunction

  function automatic logic [IW-1:0] pack_pins();
    return {tin_pin, rin_pin, cin_pin, cts_pin};
  endfunction

  task automatic step(input logic sw, input logic [OUT_W-1:0] sd, input logic cw,
                      input logic [OUT_W-1:0] cd, input logic dw, input logic [NCH-1:0] dd,
                      input logic rd, input logic [IW-1:0] pins);
    set_we = sw; set_data = sd; clr_we = cw; clr_data = cd;
    dir_we = dw; dir_data = dd; chg_rd = rd;
    {tin_pin, rin_pin, cin_pin, cts_pin} = pins;
    op_m   = op_next(op_m, sw, sd, cw, cd, dw, dd);
    flg_m  = (rd ? '0 : flg_m) | (s2_m[WW-1:0] ^ prev_m);
    prev_m = s2_m[WW-1:0];
    s2_m   = s1_m;
    s1_m   = pins;
    @(negedge clk);
    check("R1/R2/R3/R4/R5 op_q", 32'(op_q), 32'(op_m));
    check("R6 inport_q", 32'(inport_q), 32'(s2_m));
    check("R7/R8/R9/R10 chg_word", 32'(chg_word), 32'({flg_m, s2_m[WW-1:0]}));
  endtask

  task automatic idle(input logic [IW-1:0] pins);
    step(0, '0, 0, '0, 0, '0, 0, pins);
  endtask

  initial begin
    #(CLK_HALF * 2 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [IW-1:0] pins;
    void'($urandom(32'h1bad5eed));
    rst_n = 1'b0;
    set_we = 0; clr_we = 0; dir_we = 0; chg_rd = 0;
    set_data = '0; clr_data = '0; dir_data = '0;
    cts_pin = '0; cin_pin = '0; rin_pin = '0; tin_pin = '0;
    op_m = '0; s1_m = '0; s2_m = '0; prev_m = '0; flg_m = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 op_q in reset", 32'(op_q), 0);
    check("R11 inport_q in reset", 32'(inport_q), 0);
    check("R11 chg_word in reset", 32'(chg_word), 0);
    // R11 write during the release window is ignored
    rst_n = 1'b1;
    set_we = 1; set_data = '1;
    @(negedge clk);
    set_we = 0; set_data = '0;
    check("R11 write ignored during release", 32'(op_q), 0);
    @(negedge clk);
    pins = '0;

    // directed: R1 set, R2 clear, R3 collision, R4 direct write
    step(1, 4'b1100, 0, '0, 0, '0, 0, pins);
    check("R1 set upper bits", 32'(op_q), 32'hC);
    step(0, '0, 1, 4'b0100, 1, 2'b11, 0, pins);
    check("R2/R4 clear plus direct", 32'(op_q), 32'hB);
    step(1, 4'b0001, 1, 4'b0001, 0, '0, 0, pins);
    check("R3 set wins over clear", 32'(op_q[0]), 1);
    step(0, '0, 0, '0, 1, 2'b00, 0, pins);
    check("R4 direct keeps upper bits", 32'(op_q), 32'h8);
    step(1, 4'b0010, 0, '0, 1, 2'b00, 0, pins);
    check("R3 set wins over direct", 32'(op_q), 32'hA);
    idle(pins);
    check("R5 hold", 32'(op_q), 32'hA);

    // directed: R7 flag on cts[0], R8 read clears
    pins[0] = 1'b1;
    idle(pins);
    idle(pins);
    check("R6/R10 level after two edges", 32'(chg_word[0]), 1);
    idle(pins);
    check("R7 flag set", 32'(chg_word[WW]), 1);
    step(0, '0, 0, '0, 0, '0, 1, pins);
    check("R8 read clears", 32'(chg_word[2*WW-1:WW]), 0);
    // R9: cin[1] toggles so its edge lands on the read edge
    pins[NCH + 1] = 1'b1;
    idle(pins);
    idle(pins);
    step(0, '0, 0, '0, 0, '0, 1, pins);
    check("R9 edge kept on read", 32'(chg_word[WW + NCH + 1]), 1);
    // R6 rin/tin readable but not flagged
    pins[2*NCH] = 1'b1; pins[3*NCH + 1] = 1'b1;
    step(0, '0, 0, '0, 0, '0, 1, pins);
    idle(pins); idle(pins); idle(pins);
    check("R6 rin/tin levels", 32'(inport_q[IW-1:WW]), 32'({2'b10, 2'b01}));
    check("R7 rin/tin raise no flag", 32'(chg_word[2*WW-1:WW]), 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 6) == 0) pins[$urandom % IW] ^= 1'b1;
      step(($urandom % 4) == 0, OUT_W'($urandom), ($urandom % 4) == 0, OUT_W'($urandom),
           ($urandom % 4) == 0, NCH'($urandom), ($urandom % 5) == 0, pins);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule